// File: doc/BRIEF.md
# DRAM Refresh Request and Strobe Sequencer

This block times DRAM refresh and drives the row strobes of a refresh cycle. A free-running divider chain runs from the delay-line clock. A coarse stage, picked by a 3-bit code, brings the clock down to roughly 2 MHz. A fine stage, picked by one bit, then divides that intermediate rate by 30 or by 26. This gives a refresh interval of about 15 µs or 13 µs. Each time the chain wraps, the block raises a refresh request. The request stays up until the arbiter grants it.

An accepted grant starts a refresh burst on four active-low row strobes. In simultaneous mode all four strobes fall and rise together. In staggered mode the strobes fall one clock apart, and each strobe rises in the order it fell. In pair configuration a staggered burst steps in pairs: strobes 0 and 1 first, then strobes 2 and 3. Otherwise it steps one strobe at a time, from strobe 0 to strobe 3. Each strobe stays low for `LOW_CLKS` clocks, which must be at least 2. Arbitration against normal accesses happens outside this block.

Top module: `dram_rfsh_seq`

## Requirements
- R1: The coarse divisor is 10 minus the unsigned value of `div_code` (code 0 gives 10, code 7 gives 3).
- R2: With `fine_sel` = 0 the fine stage divides by 30. With `fine_sel` = 1 it divides by 26.
- R3: After reset, or after any request edge, the next request rises exactly coarse×fine clock edges later. The request stays high until a grant is accepted.
- R4: If several intervals pass without a grant, only one request is pending. One accepted grant clears it.
- R5: A grant while no request is pending has no effect. All strobes stay high.
- R6: With `stagger_en` = 0, an accepted grant drives all four `ras_n` bits low (value 4'h0) on the next edge. They stay low for `LOW_CLKS` cycles and then all return high together.
- R7: With `stagger_en` = 1 and `pair_mode` = 0, `ras_n[i]` is low from cycle i to cycle i+`LOW_CLKS`-1 of the burst. Cycle 0 is the first cycle after the accepting edge. The first step reads 4'hE.
- R8: With `stagger_en` = 1 and `pair_mode` = 1, `ras_n[1:0]` are low for cycles 0 to `LOW_CLKS`-1, and `ras_n[3:2]` are low for cycles 1 to `LOW_CLKS`. The first step reads 4'hC.
- R9: Reset drives `rfsh_req` low and `ras_n` to 4'hF, and clears both divider counters.
- R10: A grant is accepted only when `grant` and `rfsh_req` are both high and no burst is running. The request reads low in the cycle after the accepting edge, unless a new interval ends on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Delay-line clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_code | input | 3 | Coarse divisor select |
| fine_sel | input | 1 | Fine divisor select (0: /30, 1: /26) |
| stagger_en | input | 1 | 0: simultaneous strobes, 1: staggered strobes |
| pair_mode | input | 1 | Strobes step in pairs when staggered |
| grant | input | 1 | Refresh grant from the arbiter |
| rfsh_req | output | 1 | Refresh request pending |
| ras_n | output | 4 | Active-low refresh row strobes |

## Verification
The hardest case to reach is a request that stays pending while a second interval ends. In that state the pending flag must absorb the new pulse without storing a second refresh. The stimulus holds off the grant for more than one full interval after a request rises. It then grants once at a cycle that does not line up with a divider wrap. The bench checks that the request drops and that exactly one burst follows. Separate runs under reset use different code and fine settings, so each interval length is measured from a known counter state.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int NUM_RAS     = 4;
    localparam int COARSE_MAX  = 10;
    localparam int FINE_LONG   = 30;
    localparam int FINE_SHORT  = 26;

    // Coarse stage: code 0 divides by 10, each step up divides by one less.
    function automatic int coarse_divisor(input logic [2:0] code);
        return COARSE_MAX - int'(code);
    endfunction

    function automatic int fine_divisor(input logic sel);
        return sel ? FINE_SHORT : FINE_LONG;
    endfunction

    // Cycle of the burst at which strobe idx falls.
    function automatic int line_offset(input int idx, input logic stag, input logic pair);
        if (!stag)
            return 0;
        else if (pair)
            return idx / 2;
        else
            return idx;
    endfunction

    function automatic int burst_len(input logic stag, input logic pair, input int low);
        return low + line_offset(NUM_RAS - 1, stag, pair);
    endfunction

    // Set bit = strobe low during burst cycle t.
    function automatic logic [NUM_RAS-1:0] low_mask(input int t, input logic stag,
                                                    input logic pair, input int low);
        logic [NUM_RAS-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_RAS; i++) begin
            m[i] = (t >= line_offset(i, stag, pair)) && (t < line_offset(i, stag, pair) + low);
        end
        return m;
    endfunction

endpackage

// File: rtl/rfsh_coarse_div.sv
module rfsh_coarse_div
    import rfsh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] div_code,
    output logic       tick
);
    localparam int CW = $clog2(COARSE_MAX);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } coarse_st_t;

    coarse_st_t st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        st_d = st_q;
        lim  = CW'(coarse_divisor(div_code) - 1);
        tick = (st_q.cnt >= lim);
        if (tick)
            st_d.cnt = '0;
        else
            st_d.cnt = st_q.cnt + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval
    import rfsh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic fine_sel,
    input  logic accept,
    output logic req
);
    localparam int FW = $clog2(FINE_LONG);

    typedef struct packed {
        logic [FW-1:0] cnt;
        logic          req;
    } intv_st_t;

    intv_st_t st_d, st_q;
    logic [FW-1:0] lim;
    logic          wrap;

    always_comb begin
        st_d = st_q;
        lim  = FW'(fine_divisor(fine_sel) - 1);
        wrap = tick && (st_q.cnt >= lim);
        if (tick)
            st_d.cnt = wrap ? '0 : st_q.cnt + FW'(1);
        // A single flag: a second wrap while pending stores nothing extra.
        st_d.req = wrap | (st_q.req & ~accept);
        req      = st_q.req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
    import rfsh_pkg::*;
#(
    parameter int LOW_CLKS = 4
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               stagger_en,
    input  logic               pair_mode,
    output logic               busy,
    output logic [NUM_RAS-1:0] ras_n
);
    localparam int TW = $clog2(LOW_CLKS + NUM_RAS + 1);

    typedef struct packed {
        logic               busy;
        logic               stag;
        logic               pair;
        logic [TW-1:0]      t;
        logic [NUM_RAS-1:0] ras_n;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic [TW-1:0] t_nx;

    always_comb begin
        st_d = st_q;
        t_nx = st_q.t + TW'(1);
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy  = 1'b1;
                st_d.stag  = stagger_en;
                st_d.pair  = pair_mode;
                st_d.t     = '0;
                st_d.ras_n = ~low_mask(0, stagger_en, pair_mode, LOW_CLKS);
            end
        end else if (int'(t_nx) >= burst_len(st_q.stag, st_q.pair, LOW_CLKS)) begin
            st_d.busy  = 1'b0;
            st_d.t     = '0;
            st_d.ras_n = '1;
        end else begin
            st_d.t     = t_nx;
            st_d.ras_n = ~low_mask(int'(t_nx), st_q.stag, st_q.pair, LOW_CLKS);
        end
        busy  = st_q.busy;
        ras_n = st_q.ras_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.ras_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
    import rfsh_pkg::*;
#(
    parameter int LOW_CLKS = 4
)(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] div_code,
    input  logic       fine_sel,
    input  logic       stagger_en,
    input  logic       pair_mode,
    input  logic       grant,
    output logic       rfsh_req,
    output logic [3:0] ras_n
);
    logic tick;
    logic busy;
    logic accept;

    assign accept = grant & rfsh_req & ~busy;

    rfsh_coarse_div u_coarse (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_code (div_code),
        .tick     (tick)
    );

    rfsh_interval u_interval (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .fine_sel (fine_sel),
        .accept   (accept),
        .req      (rfsh_req)
    );

    rfsh_strobe_seq #(.LOW_CLKS(LOW_CLKS)) u_strobe (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept),
        .stagger_en (stagger_en),
        .pair_mode  (pair_mode),
        .busy       (busy),
        .ras_n      (ras_n)
    );

endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       grant,
    input logic       rfsh_req,
    input logic [3:0] ras_n
);
    // R9: the first sampled edge after reset sees idle outputs.
    a_r9_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ras_n == 4'hF) && !rfsh_req);

    // R3: a request never drops without a grant.
    a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_req && !grant |=> rfsh_req);

    // R5: idle strobes stay high unless a pending request is granted.
    a_r5_idle_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n == 4'hF) && !(grant && rfsh_req) |=> (ras_n == 4'hF));

    // R6, R7, R8: the first burst step is one of the three legal shapes.
    a_r8_first_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n == 4'hF) && grant && rfsh_req |=>
            (ras_n == 4'h0) || (ras_n == 4'hE) || (ras_n == 4'hC));

    // R7: a strobe rises no earlier than the strobe below it.
    for (genvar i = 1; i < 4; i++) begin : g_order
        a_r7_release_order: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ras_n[i]) |-> ras_n[i-1]);
    end

endmodule

bind dram_rfsh_seq rfsh_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .grant    (grant),
    .rfsh_req (rfsh_req),
    .ras_n    (ras_n)
);

// File: tb/test_dram_rfsh_seq.sv
module test_dram_rfsh_seq;

    localparam int LOW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] div_code = 3'd7;
    logic       fine_sel = 1'b1;
    logic       stagger_en = 1'b0;
    logic       pair_mode = 1'b0;
    logic       grant = 1'b0;
    logic       rfsh_req;
    logic [3:0] ras_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mark = 0;
    bit done = 0;

    logic [3:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    dram_rfsh_seq #(.LOW_CLKS(LOW)) i_dram_rfsh_seq (
        .clk(clk), .rst_n(rst_n), .div_code(div_code), .fine_sel(fine_sel),
        .stagger_en(stagger_en), .pair_mode(pair_mode), .grant(grant),
        .rfsh_req(rfsh_req), .ras_n(ras_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected strobe levels, written from R6/R7/R8.
    function automatic logic [3:0] exp_ras(input int t, input bit stag, input bit pair);
        logic [3:0] v;
        v = 4'hF;
        for (int i = 0; i < 4; i++) begin
            int off;
            off = !stag ? 0 : (pair ? i / 2 : i);
            if (t >= off && t < off + LOW) v[i] = 1'b0;
        end
        return v;
    endfunction

    // Monitor: compare each queued expectation with the strobes.
    always begin
        @(posedge clk);
        #2;
        if (exp_q.size() > 0) begin
            logic [3:0] e;
            string      tg;
            e  = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(ras_n === e, tg, int'(ras_n), int'(e));
        end
    end

    task automatic wait_idle();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic apply_reset(input logic [2:0] code, input bit fs, input bit st, input bit pr);
        @(negedge clk);
        rst_n = 1'b0;
        div_code = code; fine_sel = fs; stagger_en = st; pair_mode = pr;
        repeat (2) @(negedge clk);
        check(ras_n === 4'hF, "R9 ras_n in reset", int'(ras_n), 15);
        check(rfsh_req === 1'b0, "R9 req in reset", int'(rfsh_req), 0);
        rst_n = 1'b1;
        mark = cyc;
    endtask

    // Wait for a request and check the edge count since mark (R1, R2, R3).
    task automatic wait_req(input int gap, input string tag);
        int lim;
        lim = 0;
        do begin
            @(posedge clk);
            #2;
            lim++;
        end while (!rfsh_req && lim < 2000);
        check(rfsh_req === 1'b1 && (cyc - mark) == gap, tag, cyc - mark, gap);
        mark = cyc;
    endtask

    // Driver: grant once and push the expected burst (R6/R7/R8), check R10.
    task automatic do_grant(input bit st, input bit pr, input string tag);
        int len;
        @(negedge clk);
        grant = 1'b1;
        len = LOW + (!st ? 0 : (pr ? 1 : 3));
        for (int t = 0; t < len; t++) begin
            exp_q.push_back(exp_ras(t, st, pr));
            tag_q.push_back(tag);
        end
        exp_q.push_back(4'hF);
        tag_q.push_back(tag);
        @(posedge clk);
        #3;
        check(rfsh_req === 1'b0, "R10 req drops after grant", int'(rfsh_req), 0);
        @(negedge clk);
        grant = 1'b0;
        wait_idle();
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_up();
    end

    initial begin
        // R1/R2 code 7 (/3), fine /26, simultaneous strobes.
        apply_reset(3'd7, 1'b1, 1'b0, 1'b0);
        wait_req(78, "R1 R2 R9 first interval 3x26");
        do_grant(1'b0, 1'b0, "R6 simultaneous burst");
        wait_req(78, "R3 next interval 3x26");

        // R4: let a second interval end while pending, then grant once.
        repeat (100) @(posedge clk);
        #2;
        check(rfsh_req === 1'b1, "R3 req held while pending", int'(rfsh_req), 1);
        do_grant(1'b0, 1'b0, "R4 single burst after two intervals");
        repeat (5) @(posedge clk);
        #2;
        check(rfsh_req === 1'b0, "R4 no second request stored", int'(rfsh_req), 0);

        // R5: grant with nothing pending.
        @(negedge clk);
        grant = 1'b1;
        for (int k = 0; k < 6; k++) begin
            exp_q.push_back(4'hF);
            tag_q.push_back("R5 grant ignored");
        end
        repeat (2) @(negedge clk);
        grant = 1'b0;
        wait_idle();
        check(rfsh_req === 1'b0, "R5 req stays low", int'(rfsh_req), 0);

        // R7: code 0 (/10), fine /30, staggered single strobes.
        apply_reset(3'd0, 1'b0, 1'b1, 1'b0);
        wait_req(300, "R1 R2 interval 10x30");
        do_grant(1'b1, 1'b0, "R7 staggered singles");

        // R8: code 3 (/7), fine /30, staggered pairs.
        apply_reset(3'd3, 1'b0, 1'b1, 1'b1);
        wait_req(210, "R1 R2 interval 7x30");
        do_grant(1'b1, 1'b1, "R8 staggered pairs");
        wait_req(210, "R3 interval repeat 7x30");

        // R1/R2: code 5 (/5), fine /26.
        apply_reset(3'd5, 1'b1, 1'b0, 1'b0);
        wait_req(130, "R1 R2 interval 5x26");
        do_grant(1'b0, 1'b0, "R6 simultaneous burst again");

        repeat (4) @(negedge clk);
        finish_up();
    end

endmodule